// File: doc/BRIEF.md
# Frame-Position Pixel Capture Unit

This block sits on a parallel pixel stream that arrives one word per pixel clock together with a frame-start marker. It keeps a running count of the pixel position within the current frame. When that count equals a position chosen by a host microcontroller, it latches the single pixel word found there into a holding register and raises a ready flag. The host then reads the word at its own pace.

The host drives three strobes: load a target position, arm, and acknowledge a read. Each strobe passes through a two-flop synchronizer and an edge detector, so a level held high acts only once. The target value itself is treated as quasi-static: the host sets it up before raising the load strobe and holds it until the strobe is released. After arming, the unit captures on the first position match and then disarms. It stays quiet until the host arms it again, so the host can read without a race.

The position counter restarts from zero on frame sync. If no sync arrives it saturates at its all-ones value, and that value is reserved and never matches. A target beyond the real frame length therefore simply never fires. The same holds after reset, before the first sync has been seen.

Top module: `pcap_unit`

## Requirements
- R1: The pixel presented in a cycle where `frame_sync` is high has position 0; each following cycle without sync has position one greater than the previous one.
- R2: While armed, the pixel whose position equals the target is loaded into `cap_word`. On the same clock edge `cap_ready` becomes 1 and `armed` becomes 0.
- R3: Only the first match after arming loads `cap_word`. Later frames leave `cap_word` and `cap_ready` untouched until the host arms again.
- R4: `cap_ready` is cleared by a read strobe (`host_rd`) and by an arm strobe (`host_arm`).
- R5: A target load (`host_wr`) is ignored while `armed` is 1; the previously loaded target stays in force.
- R6: A target position that is not smaller than the frame length never matches, and the unit stays armed with `cap_ready` at 0 across such frames.
- R7: Without sync, the position saturates at 2^POS_W-1 instead of wrapping. That saturated position never matches, including after reset and before the first sync.
- R8: A strobe first sampled high at clock edge k takes effect at edge k+2. Holding it high acts only once.
- R9: After reset, `armed` and `cap_ready` are 0, `cap_word` is 0 and the target is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | PIX_W | Pixel word for the current clock |
| frame_sync | input | 1 | High on the first pixel of a frame |
| host_tgt | input | POS_W | Target position, held stable while `host_wr` is high |
| host_wr | input | 1 | Strobe: load `host_tgt` as the target |
| host_arm | input | 1 | Strobe: arm for one capture, clear ready |
| host_rd | input | 1 | Strobe: acknowledge read, clear ready |
| cap_word | output | PIX_W | Captured pixel word |
| cap_ready | output | 1 | A captured word is waiting |
| armed | output | 1 | Waiting for the target position |

## Verification
The hardest case to reach is saturation. With the full 19-bit counter, the all-ones position is half a million pixels away from any sync. The bench therefore builds the unit with a 10-bit position. It holds sync low for over a thousand cycles, captures at the last position below saturation, and then shows that an armed target equal to the saturated value never fires. Arming before any sync has been seen exercises the reset-time saturated state. Frames shorter than the target show that the unit stays armed.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int unsigned PCAP_PIX_W = 10;
    localparam int unsigned PCAP_POS_W = 19;
    localparam int unsigned PCAP_SYNC_STAGES = 2;

    typedef enum int unsigned {
        HOST_WR  = 0,
        HOST_RD  = 1,
        HOST_ARM = 2
    } host_op_e;

    localparam int unsigned HOST_OPS = 3;

endpackage

// File: rtl/pcap_strobe_sync.sv
module pcap_strobe_sync #(
    parameter int unsigned STAGES = pcap_pkg::PCAP_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic pulse
);

    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], strobe_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

    // R8: a held level produces a single-cycle pulse
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/pcap_pos_counter.sv
module pcap_pos_counter #(
    parameter int unsigned POS_W = pcap_pkg::PCAP_POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    output logic [POS_W-1:0] pos,
    output logic             pos_live
);

    localparam logic [POS_W-1:0] POS_SAT = '1;

    typedef struct packed {
        logic [POS_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        if (frame_sync)
            cur_pos = '0;
        else if (st_q.cnt == POS_SAT)
            cur_pos = POS_SAT;
        else
            cur_pos = st_q.cnt + 1'b1;
        st_d     = st_q;
        st_d.cnt = cur_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= POS_SAT;
        else        st_q     <= st_d;
    end

    assign pos      = cur_pos;
    assign pos_live = (cur_pos != POS_SAT);

    // R1: sync restarts the count at zero
    assert_sync_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (st_q.cnt == '0));

    // R1: count advances by one between syncs below saturation
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && st_q.cnt != POS_SAT) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R7: saturated count holds without sync
    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && st_q.cnt == POS_SAT) |=> (st_q.cnt == POS_SAT));

endmodule

// File: rtl/pcap_capture_ctrl.sv
module pcap_capture_ctrl #(
    parameter int unsigned PIX_W = pcap_pkg::PCAP_PIX_W,
    parameter int unsigned POS_W = pcap_pkg::PCAP_POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [POS_W-1:0] pos,
    input  logic             pos_live,
    input  logic [POS_W-1:0] tgt_in,
    input  logic             wr_p,
    input  logic             rd_p,
    input  logic             arm_p,
    output logic [PIX_W-1:0] cap_word,
    output logic             cap_ready,
    output logic             armed
);

    typedef struct packed {
        logic             armed;
        logic             ready;
        logic [POS_W-1:0] tgt;
        logic [PIX_W-1:0] cap;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     hit;
    logic     take;

    assign hit  = pos_live && (pos == st_q.tgt);
    assign take = st_q.armed && hit;

    always_comb begin
        st_d = st_q;
        if (wr_p && !st_q.armed)
            st_d.tgt = tgt_in;
        if (rd_p)
            st_d.ready = 1'b0;
        if (take) begin
            st_d.cap   = pix_data;
            st_d.ready = 1'b1;
            st_d.armed = 1'b0;
        end
        if (arm_p) begin
            st_d.armed = 1'b1;
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_word  = st_q.cap;
    assign cap_ready = st_q.ready;
    assign armed     = st_q.armed;

    // R2: a match while armed latches the pixel and disarms
    assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !arm_p) |=> (st_q.ready && !st_q.armed && st_q.cap == $past(pix_data)));

    // R3: the holding register only changes through a capture
    assert_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> $stable(st_q.cap));

    // R4: a read without a simultaneous capture clears ready
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_p && !take) |=> !st_q.ready);

    // R5: target frozen while armed
    assert_target_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> $stable(st_q.tgt));

    // R7: saturated position never captures
    assert_sat_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_live && !arm_p && st_q.armed) |=> st_q.armed);

endmodule

// File: rtl/pcap_unit.sv
module pcap_unit #(
    parameter int unsigned PIX_W = pcap_pkg::PCAP_PIX_W,
    parameter int unsigned POS_W = pcap_pkg::PCAP_POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             frame_sync,
    input  logic [POS_W-1:0] host_tgt,
    input  logic             host_wr,
    input  logic             host_arm,
    input  logic             host_rd,
    output logic [PIX_W-1:0] cap_word,
    output logic             cap_ready,
    output logic             armed
);

    import pcap_pkg::*;

    logic [HOST_OPS-1:0] strobe_raw;
    logic [HOST_OPS-1:0] strobe_pulse;
    logic [POS_W-1:0]    pos;
    logic                pos_live;

    assign strobe_raw[HOST_WR]  = host_wr;
    assign strobe_raw[HOST_RD]  = host_rd;
    assign strobe_raw[HOST_ARM] = host_arm;

    for (genvar i = 0; i < HOST_OPS; i++) begin : g_sync
        pcap_strobe_sync #(.STAGES(PCAP_SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_in (strobe_raw[i]),
            .pulse     (strobe_pulse[i])
        );
    end

    pcap_pos_counter #(.POS_W(POS_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .pos        (pos),
        .pos_live   (pos_live)
    );

    pcap_capture_ctrl #(.PIX_W(PIX_W), .POS_W(POS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_data  (pix_data),
        .pos       (pos),
        .pos_live  (pos_live),
        .tgt_in    (host_tgt),
        .wr_p      (strobe_pulse[HOST_WR]),
        .rd_p      (strobe_pulse[HOST_RD]),
        .arm_p     (strobe_pulse[HOST_ARM]),
        .cap_word  (cap_word),
        .cap_ready (cap_ready),
        .armed     (armed)
    );

    // R9: outputs idle in the first cycle after reset
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!armed && !cap_ready && cap_word == '0));

endmodule

// File: tb/sim_pcap_unit.sv
module sim_pcap_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 10;
    localparam int POS_W = 10;
    localparam logic [POS_W-1:0] SAT = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic             frame_sync = 1'b0;
    logic [POS_W-1:0] host_tgt = '0;
    logic             host_wr = 1'b0;
    logic             host_arm = 1'b0;
    logic             host_rd = 1'b0;
    logic [PIX_W-1:0] cap_word;
    logic             cap_ready;
    logic             armed;

    pcap_unit #(.PIX_W(PIX_W), .POS_W(POS_W)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // scoreboard state
    logic [PIX_W-1:0] exp_q[$];
    logic [POS_W-1:0] bpos = SAT;
    int               frame_no = 0;
    bit               m_armed = 1'b0;
    logic [POS_W-1:0] m_tgt = '0;
    logic [PIX_W-1:0] last_cap = '0;
    bit               mon_on = 1'b0;
    logic             prev_ready = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [PIX_W-1:0] pixf(input int fr, input logic [POS_W-1:0] p);
        return PIX_W'((fr * 97 + int'(p) * 13 + 5) % (1 << PIX_W));
    endfunction

    // driver: one pixel per call, model pushes expected captures
    task automatic step(input bit s);
        frame_sync = s;
        if (s) begin
            bpos = '0;
            frame_no++;
        end else if (bpos != SAT) begin
            bpos = bpos + 1'b1;
        end
        pix_data = pixf(frame_no, bpos);
        if (m_armed && bpos != SAT && bpos == m_tgt) begin
            exp_q.push_back(pix_data);
            last_cap = pix_data;
            m_armed = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input int len);
        step(1'b1);
        for (int i = 1; i < len; i++) step(1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic host_write(input logic [POS_W-1:0] v);
        host_tgt = v;
        host_wr = 1'b1;
        idle(3);
        host_wr = 1'b0;
        if (!m_armed) m_tgt = v;
        idle(2);
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        idle(3);
        host_rd = 1'b0;
        idle(2);
    endtask

    task automatic host_do_arm(input bit check_timing);
        host_arm = 1'b1;
        step(1'b0);  // edge k samples the strobe
        step(1'b0);  // edge k+1
        if (check_timing) chk("R8 armed before effect edge", {31'd0, armed}, 32'd0);
        step(1'b0);  // edge k+2: arm takes effect
        if (check_timing) chk("R8 armed at edge k+2", {31'd0, armed}, 32'd1);
        m_armed = 1'b1;
        idle(3);
        host_arm = 1'b0;
        idle(2);
        chk("R8 held arm acts once", {31'd0, armed}, {31'd0, m_armed});
    endtask

    // monitor: compares each new capture against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (cap_ready && !prev_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R3 unexpected capture actual=%0d expected=none", cap_word);
                end else begin
                    logic [PIX_W-1:0] e;
                    e = exp_q.pop_front();
                    if (cap_word !== e) begin
                        errors++;
                        $display("FAIL R2 captured word actual=%0d expected=%0d", cap_word, e);
                    end
                end
            end
            prev_ready = cap_ready;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PIX_W-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0);
        // R9 reset state
        chk("R9 armed after reset", {31'd0, armed}, 32'd0);
        chk("R9 ready after reset", {31'd0, cap_ready}, 32'd0);
        chk("R9 word after reset", {22'd0, cap_word}, 32'd0);
        mon_on = 1'b1;

        // R7: armed before any sync, position saturated, no capture
        host_write(10'd5);
        host_do_arm(1'b1);
        idle(30);
        chk("R7 no capture before first sync", {31'd0, cap_ready}, 32'd0);
        chk("R7 stays armed before sync", {31'd0, armed}, 32'd1);

        // R1 R2: capture at position 5
        run_frame(50);
        chk("R2 disarmed after capture", {31'd0, armed}, 32'd0);
        chk("R2 ready after capture", {31'd0, cap_ready}, 32'd1);
        chk("R1 word is position 5 of frame", {22'd0, cap_word}, {22'd0, pixf(1, 10'd5)});

        // R3: later frames do not overwrite
        held = cap_word;
        run_frame(50);
        run_frame(50);
        chk("R3 word unchanged", {22'd0, cap_word}, {22'd0, held});
        chk("R3 ready held", {31'd0, cap_ready}, 32'd1);

        // R4: read clears ready
        host_read();
        chk("R4 read clears ready", {31'd0, cap_ready}, 32'd0);

        // R5: write while armed ignored
        host_write(10'd12);
        host_do_arm(1'b0);
        host_write(10'd30);
        run_frame(50);
        chk("R5 capture at old target", {22'd0, cap_word}, {22'd0, pixf(frame_no, 10'd12)});

        // R4: arm clears ready; R6: short frames never match
        host_do_arm(1'b0);
        chk("R4 arm clears ready", {31'd0, cap_ready}, 32'd0);
        run_frame(8);
        run_frame(8);
        run_frame(12);
        chk("R6 still armed", {31'd0, armed}, 32'd1);
        chk("R6 no ready", {31'd0, cap_ready}, 32'd0);
        run_frame(40);
        chk("R6 capture once frame is long enough", {22'd0, cap_word}, {22'd0, last_cap});

        // R7: long frame reaches the last live position
        host_write(SAT - 1'b1);
        host_do_arm(1'b0);
        run_frame(1100);
        chk("R7 capture at last live position", {22'd0, cap_word}, {22'd0, pixf(frame_no, SAT - 1'b1)});
        host_read();

        // R7: saturated position never matches
        host_write(SAT);
        host_do_arm(1'b0);
        idle(200);
        chk("R7 saturated target no capture", {31'd0, cap_ready}, 32'd0);
        run_frame(1100);
        chk("R7 stays armed past saturation", {31'd0, armed}, 32'd1);
        chk("R7 ready stays low", {31'd0, cap_ready}, 32'd0);

        idle(4);
        chk("R2 all expected captures seen", exp_q.size(), 32'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule